// File: doc/BRIEF.md
# Peripheral Bus Timeout Monitor

This block watches each transfer on a peripheral bus and makes sure it finishes within a bounded number of system clock cycles. A transfer begins in any cycle where at least one peripheral module enable is high. The addressed peripheral holds the transfer-wait line high while it is still busy. The monitor counts the cycles in which the transfer is still waiting. If that count reaches the programmed limit before the peripheral lets go of the wait line, the monitor ends the transfer itself. It does this by raising a one-cycle forced-done strobe together with a one-cycle error flag, and both go back toward the system bus master.

A four-bit configuration register sets the behaviour. The top bit turns timeouts on or off. The low three bits select a power-of-two limit from 8 to 1024 cycles. Software should pick a limit longer than the slowest peripheral's response, so that only a hung peripheral ever trips the monitor. When a peripheral answers in the very cycle the limit would be reached, the transfer ends normally and no error is raised.

Top module: `pbus_watchdog`

## Requirements
- R1: After reset the configuration reads back 4'b1111 (timeouts enabled, select 7, limit 1024 cycles), and force_done and bus_err are low.
- R2: A cycle with cfg_we high loads cfg_wdata into the configuration, and the new value is visible on cfg_rdata in the next cycle. Bit 3 is the timeout enable and bits 2:0 are the select s. The limit L is 8 << s.
- R3: A transfer whose xfr_wait stays high for L consecutive cycles, with any mod_en bit high, times out. force_done rises in the cycle after the L-th waiting cycle. Any single mod_en bit, or several at once, can start a transfer.
- R4: force_done and bus_err are each high for exactly one cycle per timeout, and always in the same cycle.
- R5: A cycle with a module enable high and xfr_wait low ends the transfer normally and clears the count. An enabled cycle that follows it starts a new transfer counted from zero, even when the enable never dropped.
- R6: If xfr_wait is low in the L-th cycle of a transfer, the transfer ends normally and no error pulse follows.
- R7: While the enable bit (bit 3) is clear, no force_done or bus_err pulse is produced, however long xfr_wait stays high.
- R8: Bus inputs in the cycle in which force_done is high are ignored. Counting for the next transfer starts in the following cycle.
- R9: A cycle with all mod_en bits low clears the count, and no pulse follows such a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_en | input | N_MODS | Peripheral module enables; any bit high marks a transfer cycle |
| xfr_wait | input | 1 | High while the addressed peripheral is still busy |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | SEL_W+1 | Configuration write data: enable in the top bit, select below |
| cfg_rdata | output | SEL_W+1 | Current configuration value |
| force_done | output | 1 | One-cycle forced transfer completion |
| bus_err | output | 1 | One-cycle error response paired with force_done |

## Verification
The bench targets the exact boundary between a late answer and a timeout. A transfer that answers in its L-th cycle must pass cleanly, while one still waiting in that cycle must be cut off one cycle later. An off-by-one counter would either flag the late answer or report the pulse a cycle early or late. Two short transfers run back to back with the enable held high, and their combined length exceeds the limit. A counter that does not clear on normal termination would raise a false error there. The bench also keeps the bus stalled through the forced-done cycle and then runs a transfer just under the limit. A design that counts during that cycle would time this transfer out. Finally it checks the smallest and largest limits, the disabled mode and several enable patterns.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  localparam int unsigned PBW_SEL_W     = 3;
  localparam int unsigned PBW_MIN_SHIFT = 3;
  localparam int unsigned PBW_N_MODS    = 8;

  typedef enum logic {
    ST_RUN   = 1'b0,
    ST_FLUSH = 1'b1
  } pbw_state_e;
endpackage

// File: rtl/pbw_cfg.sv
module pbw_cfg #(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned MIN_SHIFT = 3,
  parameter int unsigned CNT_W     = 10,
  parameter bit          RST_EN    = 1'b1,
  parameter int unsigned RST_SEL   = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W:0]   wdata,
  output logic [SEL_W:0]   rdata,
  output logic             ena,
  output logic [CNT_W-1:0] lim_m1
);
  localparam int unsigned LIM_W = CNT_W + 1;

  logic             en_q;
  logic [SEL_W-1:0] sel_q;
  logic [LIM_W-1:0] lim_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= RST_EN;
      sel_q <= SEL_W'(RST_SEL);
    end else if (we) begin
      en_q  <= wdata[SEL_W];
      sel_q <= wdata[SEL_W-1:0];
    end
  end

  // limit = 2^(MIN_SHIFT + sel); compare value is limit - 1
  always_comb begin
    lim_full = LIM_W'(1) << (MIN_SHIFT + 32'(sel_q));
    lim_m1   = CNT_W'(lim_full - LIM_W'(1));
  end

  assign ena   = en_q;
  assign rdata = {en_q, sel_q};
endmodule

// File: rtl/pbw_count.sv
module pbw_count #(
  parameter int unsigned N_MODS = 8,
  parameter int unsigned CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_MODS-1:0] mod_en,
  input  logic              xfr_wait,
  input  logic              blank,
  input  logic              ena,
  input  logic [CNT_W-1:0]  lim_m1,
  output logic              hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             any_en;
  logic             stalled;
  logic [CNT_W-1:0] cnt_q;

  assign any_en  = |mod_en;
  assign stalled = any_en & xfr_wait & ~blank;

  // Timeout when still waiting in the limit-th cycle; >= tolerates a
  // limit lowered in the middle of a transfer.
  always_comb hit = ena & stalled & (cnt_q >= lim_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (!stalled || hit) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pbw_resp.sv
module pbw_resp
  import pbw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit,
  output logic blank,
  output logic force_done,
  output logic bus_err
);
  pbw_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_RUN;
      force_done <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      force_done <= hit;
      bus_err    <= hit;
      state_q    <= hit ? ST_FLUSH : ST_RUN;
    end
  end

  assign blank = (state_q == ST_FLUSH);
endmodule

// File: rtl/pbus_watchdog.sv
module pbus_watchdog
  import pbw_pkg::*;
#(
  parameter int unsigned N_MODS    = PBW_N_MODS,
  parameter int unsigned SEL_W     = PBW_SEL_W,
  parameter int unsigned MIN_SHIFT = PBW_MIN_SHIFT,
  parameter bit          RST_EN    = 1'b1,
  parameter int unsigned RST_SEL   = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_MODS-1:0] mod_en,
  input  logic              xfr_wait,
  input  logic              cfg_we,
  input  logic [SEL_W:0]    cfg_wdata,
  output logic [SEL_W:0]    cfg_rdata,
  output logic              force_done,
  output logic              bus_err
);
  localparam int unsigned CNT_W = MIN_SHIFT + (1 << SEL_W) - 1;

  logic             ena;
  logic [CNT_W-1:0] lim_m1;
  logic             hit;
  logic             blank;

  pbw_cfg #(
    .SEL_W(SEL_W), .MIN_SHIFT(MIN_SHIFT), .CNT_W(CNT_W),
    .RST_EN(RST_EN), .RST_SEL(RST_SEL)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .ena(ena), .lim_m1(lim_m1)
  );

  pbw_count #(.N_MODS(N_MODS), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .mod_en(mod_en), .xfr_wait(xfr_wait),
    .blank(blank), .ena(ena), .lim_m1(lim_m1), .hit(hit)
  );

  pbw_resp u_resp (
    .clk(clk), .rst(rst), .hit(hit), .blank(blank),
    .force_done(force_done), .bus_err(bus_err)
  );
endmodule

// File: rtl/pbw_checker.sv
module pbw_checker #(
  parameter int unsigned N_MODS = 8,
  parameter int unsigned SEL_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [N_MODS-1:0] mod_en,
  input logic              xfr_wait,
  input logic [SEL_W:0]    cfg_rdata,
  input logic              force_done,
  input logic              bus_err
);
  logic [11:0] run_q;

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if ((|mod_en) && xfr_wait) begin
      if (run_q != 12'hfff) run_q <= run_q + 12'd1;
    end else run_q <= '0;
  end

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    force_done |=> !force_done);
  a_r4_err_paired: assert property (@(posedge clk) disable iff (rst)
    force_done == bus_err);
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !cfg_rdata[SEL_W] |=> !force_done);
  a_r6_answer_wins: assert property (@(posedge clk) disable iff (rst)
    !xfr_wait |=> !force_done);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    (mod_en == '0) |=> !force_done);
  a_r3_min_stall: assert property (@(posedge clk) disable iff (rst)
    force_done |-> (run_q >= 12'd8));
endmodule

bind pbus_watchdog pbw_checker #(.N_MODS(N_MODS), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .mod_en(mod_en), .xfr_wait(xfr_wait),
  .cfg_rdata(cfg_rdata), .force_done(force_done), .bus_err(bus_err)
);

// File: tb/sim_pbus_watchdog.sv
module sim_pbus_watchdog;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] mod_en = '0;
  logic       xfr_wait = 1'b0;
  logic       cfg_we = 1'b0;
  logic [3:0] cfg_wdata = '0;
  logic [3:0] cfg_rdata;
  logic       force_done, bus_err;

  int checks = 0, errors = 0, cyc = 0, pulses = 0;
  bit done = 1'b0;
  int exp_q[$];

  pbus_watchdog u0 (
    .clk(clk), .rst(rst), .mod_en(mod_en), .xfr_wait(xfr_wait),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .force_done(force_done), .bus_err(bus_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: every pulse must match the next expected cycle
  always @(negedge clk) begin
    if (!rst && (force_done || bus_err)) begin
      pulses++;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected pulse at cycle %0d actual done=%0b err=%0b expected none",
                 cyc, force_done, bus_err);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != cyc || !(force_done && bus_err)) begin
          errors++;
          $display("FAIL R3 pulse actual cycle %0d done=%0b err=%0b expected cycle %0d both high",
                   cyc, force_done, bus_err, e);
        end
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mod_en = '0; xfr_wait = 1'b0;
    end
  endtask

  task automatic cfg_write(input logic [3:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
    checks++;
    if (cfg_rdata !== v) begin
      errors++;
      $display("FAIL R2 cfg readback actual %h expected %h", cfg_rdata, v);
    end
  endtask

  // lim = 0: no timeout expected. hold: keep bus stalled in the pulse cycle.
  task automatic xfer(input logic [7:0] en, input int nwait, input int lim, input bit hold);
    if (lim > 0 && nwait >= lim) begin
      for (int i = 0; i < lim; i++) begin
        @(negedge clk);
        if (i == 0) exp_q.push_back(cyc + lim);
        mod_en = en; xfr_wait = 1'b1;
      end
      @(negedge clk);
      if (hold) begin mod_en = en; xfr_wait = 1'b1; end
      else begin mod_en = '0; xfr_wait = 1'b0; end
    end else begin
      for (int i = 0; i < nwait; i++) begin
        @(negedge clk);
        mod_en = en; xfr_wait = 1'b1;
      end
      @(negedge clk);
      mod_en = en; xfr_wait = 1'b0;
    end
  endtask

  task automatic expect_pulses(input int p0, input int n, input string req);
    checks++;
    if (pulses - p0 != n) begin
      errors++;
      $display("FAIL %s pulse count actual %0d expected %0d", req, pulses - p0, n);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (cfg_rdata !== 4'b1111 || force_done !== 1'b0 || bus_err !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset actual cfg=%h done=%0b err=%0b expected cfg=f done=0 err=0",
               cfg_rdata, force_done, bus_err);
    end

    // R3 default limit 1024 before any write
    p0 = pulses; xfer(8'h01, 1100, 1024, 0); idle(2); expect_pulses(p0, 1, "R3");

    // R2 select 0 -> limit 8
    cfg_write(4'b1000);
    p0 = pulses; xfer(8'h02, 3, 0, 0); idle(2); expect_pulses(p0, 0, "R5");
    // R6 answer in the 8th cycle
    p0 = pulses; xfer(8'h80, 7, 0, 0); idle(2); expect_pulses(p0, 0, "R6");
    // R3 still waiting in 8th cycle, several enables
    p0 = pulses; xfer(8'h81, 8, 8, 0); idle(2); expect_pulses(p0, 1, "R3");
    // R5 back-to-back 5+5 with enable held
    p0 = pulses; xfer(8'h04, 5, 0, 0); xfer(8'h04, 5, 0, 0); idle(2);
    expect_pulses(p0, 0, "R5");
    // R9 enable drop mid-stall clears count
    p0 = pulses; xfer(8'h10, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin @(negedge clk); mod_en = 8'h10; xfr_wait = 1'b1; end
    @(negedge clk); mod_en = '0; xfr_wait = 1'b1;
    for (int i = 0; i < 6; i++) begin @(negedge clk); mod_en = 8'h10; xfr_wait = 1'b1; end
    @(negedge clk); mod_en = 8'h10; xfr_wait = 1'b0;
    idle(2); expect_pulses(p0, 0, "R9");
    // R8 stall held through pulse cycle, then 7-wait transfer must pass
    p0 = pulses; xfer(8'h20, 8, 8, 1); xfer(8'h20, 7, 0, 0); idle(2);
    expect_pulses(p0, 1, "R8");

    // R2 select 2 -> limit 32
    cfg_write(4'b1010);
    p0 = pulses; xfer(8'h08, 31, 0, 0); idle(2); expect_pulses(p0, 0, "R6");
    p0 = pulses; xfer(8'hff, 40, 32, 0); idle(2); expect_pulses(p0, 1, "R3");

    // R7 disabled, limit field 8, long stall
    cfg_write(4'b0000);
    p0 = pulses; xfer(8'h40, 50, 0, 0); idle(3); expect_pulses(p0, 0, "R7");

    // R2 select 7 -> limit 1024 again
    cfg_write(4'b1111);
    p0 = pulses; xfer(8'h01, 1023, 0, 0); idle(2); expect_pulses(p0, 0, "R6");

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 missing pulses actual %0d outstanding expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule